// File: doc/BRIEF.md
# Universal Bidirectional Bus Register

This block joins two data buses, called A and B, with one storage path in each direction. Each path has three modes. In transparent mode the destination follows the source. In hold mode the path keeps a stored word. In capture mode the path loads a new word on a rising edge of its own capture strobe. Each path has three controls: a follow (latch) enable, a capture strobe and an output enable. The two output enables have opposite polarity. The A-to-B enable is active high and the B-to-A enable is active low.

The buses are modelled without tri-state pads. Each side has an input vector, an output vector and a drive-enable vector. A drive vector of all zeros marks the high-impedance state. A free-running system clock samples the controls. The capture strobe is edge-detected against its previous sample. The output enable takes effect one system-clock cycle after it is sampled. In transparent mode the data reaches the output in the same cycle, through combinational logic.

Top module: `dual_bus_register`

## Requirements
- R1: While a path's follow enable is high and its driver is enabled, that path's output equals its source input in the same cycle, combinationally.
- R2: On every system-clock edge at which the follow enable is high, the source word is written to storage. After the follow enable falls, the output shows the word sampled at the last edge at which the enable was high.
- R3: While the follow enable is low and the capture strobe shows no rising edge, the stored word and the enabled output stay unchanged, whatever the source input does.
- R4: While the follow enable is low, a capture strobe sampled 0 at one system-clock edge and 1 at the next loads the source word present at that second edge. The new word appears on the output after that edge.
- R5: The A-to-B output enable is active high and is registered. One edge after it is sampled as 1, `bDrv` is all ones. One edge after it is sampled as 0, `bDrv` is all zeros and `bOut` is all zeros.
- R6: The B-to-A path behaves in the same way, using its own three controls. Its output enable is active low: a sampled 0 enables `aDrv` and `aOut`, and a sampled 1 disables them to all zeros.
- R7: A synchronous reset clears both stored words to zero and disables both drivers. It also records each capture strobe's previous sample as 1, so a strobe that is already high after reset does not load.
- R8: The two paths are independent. The data width is the parameter `WIDTH`, 18 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | WIDTH | Word received from the A bus |
| aOut | output | WIDTH | Word driven onto the A bus (zero when not driving) |
| aDrv | output | WIDTH | A-bus drive enable per bit; all zeros means high impedance |
| bIn | input | WIDTH | Word received from the B bus |
| bOut | output | WIDTH | Word driven onto the B bus (zero when not driving) |
| bDrv | output | WIDTH | B-bus drive enable per bit; all zeros means high impedance |
| abFollow | input | 1 | A-to-B follow enable (transparent when high) |
| abStrobe | input | 1 | A-to-B capture strobe, rising-edge active |
| abDriveEn | input | 1 | A-to-B output enable, active high |
| baFollow | input | 1 | B-to-A follow enable (transparent when high) |
| baStrobe | input | 1 | B-to-A capture strobe, rising-edge active |
| baDriveEnN | input | 1 | B-to-A output enable, active low |

## Verification
The bench targets the moment the follow enable falls. A design that stored only on strobe edges would then show a stale word instead of the last transparent one. It also holds the strobe steady high after reset and after the follow enable falls. An edge detector that compared the strobe against the level rather than the previous sample would load there, and the output would move while it should hold. It drives each enable in both polarities and checks that disabled drivers read all zeros on both the drive and data vectors. A design with swapped polarity in the B-to-A direction, or with an unregistered enable, shows up as a one-cycle or full mismatch. Long random runs with random source data check that the two directions never disturb each other.

// File: rtl/dual_bus_register_pkg.sv
package dual_bus_register_pkg;
  // Strobes passed from a path's control to its datapath
  typedef struct packed {
    logic follow;  // transparent mode: output from input, storage tracks input
    logic load;    // write storage at this clock edge
    logic drive;   // driver enabled (registered)
  } pathCtrl_t;
endpackage

// File: rtl/dual_bus_register_ctrl.sv
module dual_bus_register_ctrl
  import dual_bus_register_pkg::*;
#(
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      followEn,
  input  logic      strobe,
  input  logic      outEnRaw,
  output pathCtrl_t strb
);
  logic strobePrev;
  logic driveQ;
  logic outEnActive;
  logic strobeRise;

  generate
    if (OE_ACTIVE_LOW) begin : g_oeLow
      assign outEnActive = ~outEnRaw;
    end else begin : g_oeHigh
      assign outEnActive = outEnRaw;
    end
  endgenerate

  assign strobeRise = strobe & ~strobePrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobePrev <= 1'b1;
      driveQ     <= 1'b0;
    end else begin
      strobePrev <= strobe;
      driveQ     <= outEnActive;
    end
  end

  always_comb begin
    strb.follow = followEn;
    strb.load   = followEn | strobeRise;
    strb.drive  = driveQ;
  end

  // R7
  reset_disables_chk: assert property (@(posedge clk) rst |=> !strb.drive);

  // R5
  drive_follows_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> strb.drive == (OE_ACTIVE_LOW ? !$past(outEnRaw) : $past(outEnRaw)));

  // R4
  edge_loads_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && strobe && !$past(strobe)) |-> strb.load);

  // R3
  steady_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!followEn && strobe == $past(strobe)) |-> !strb.load);
endmodule

// File: rtl/dual_bus_register_path.sv
module dual_bus_register_path
  import dual_bus_register_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  pathCtrl_t        strb,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] drv
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] store;
  logic [WIDTH-1:0] selected;

  always_ff @(posedge clk) begin
    if (rst)            store <= '0;
    else if (strb.load) store <= din;
  end

  assign selected = strb.follow ? din : store;
  assign dout     = strb.drive ? selected : '0;
  assign drv      = strb.drive ? ALL_ONES : '0;

  // R4
  load_takes_input_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> store == $past(din));

  // R3
  hold_keeps_store_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(store));

  // R5
  hiz_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (drv == '0) |-> (dout == '0));

  // R5
  drv_all_or_none_chk: assert property (@(posedge clk) disable iff (rst)
    (drv == '0) || (drv == ALL_ONES));
endmodule

// File: rtl/dual_bus_register.sv
module dual_bus_register
  import dual_bus_register_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aDrv,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bDrv,
  input  logic             abFollow,
  input  logic             abStrobe,
  input  logic             abDriveEn,
  input  logic             baFollow,
  input  logic             baStrobe,
  input  logic             baDriveEnN
);
  pathCtrl_t abStrb;
  pathCtrl_t baStrb;

  // A to B: enable active high (R5)
  dual_bus_register_ctrl #(.OE_ACTIVE_LOW(1'b0)) u_abCtrl (
    .clk(clk), .rst(rst), .followEn(abFollow), .strobe(abStrobe),
    .outEnRaw(abDriveEn), .strb(abStrb));

  dual_bus_register_path #(.WIDTH(WIDTH)) u_abPath (
    .clk(clk), .rst(rst), .din(aIn), .strb(abStrb), .dout(bOut), .drv(bDrv));

  // B to A: enable active low (R6)
  dual_bus_register_ctrl #(.OE_ACTIVE_LOW(1'b1)) u_baCtrl (
    .clk(clk), .rst(rst), .followEn(baFollow), .strobe(baStrobe),
    .outEnRaw(baDriveEnN), .strb(baStrb));

  dual_bus_register_path #(.WIDTH(WIDTH)) u_baPath (
    .clk(clk), .rst(rst), .din(bIn), .strb(baStrb), .dout(aOut), .drv(aDrv));

  // R1
  ab_transparent_chk: assert property (@(posedge clk) disable iff (rst)
    (abFollow && bDrv != '0) |-> bOut == aIn);

  // R6
  ba_transparent_chk: assert property (@(posedge clk) disable iff (rst)
    (baFollow && aDrv != '0) |-> aOut == bIn);
endmodule

// File: tb/dual_bus_register_tb.sv
`timescale 1ns/1ps
module dual_bus_register_tb;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] aIn, bIn, aOut, aDrv, bOut, bDrv;
  logic abFollow, abStrobe, abDriveEn, baFollow, baStrobe, baDriveEnN;

  int tests = 0;
  int fails = 0;

  // model state
  logic [W-1:0] mAbStore, mBaStore;
  logic mAbPrev, mBaPrev, mAbDrive, mBaDrive;

  always #4 clk = ~clk;

  dual_bus_register #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .aIn(aIn), .aOut(aOut), .aDrv(aDrv),
    .bIn(bIn), .bOut(bOut), .bDrv(bDrv),
    .abFollow(abFollow), .abStrobe(abStrobe), .abDriveEn(abDriveEn),
    .baFollow(baFollow), .baStrobe(baStrobe), .baDriveEnN(baDriveEnN));

  always @(posedge clk) begin
    if (rst) begin
      mAbStore <= '0; mBaStore <= '0;
      mAbPrev <= 1'b1; mBaPrev <= 1'b1;
      mAbDrive <= 1'b0; mBaDrive <= 1'b0;
    end else begin
      if (abFollow || (abStrobe && !mAbPrev)) mAbStore <= aIn;
      if (baFollow || (baStrobe && !mBaPrev)) mBaStore <= bIn;
      mAbPrev <= abStrobe; mBaPrev <= baStrobe;
      mAbDrive <= abDriveEn; mBaDrive <= !baDriveEnN;
    end
  end

  function automatic logic [W-1:0] expOut(logic drive, logic follow,
                                          logic [W-1:0] din, logic [W-1:0] st);
    if (!drive) return '0;
    return follow ? din : st;
  endfunction

  function automatic logic [W-1:0] expDrv(logic drive);
    return drive ? {W{1'b1}} : '0;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkAll(string abReq, string baReq);
    chk(abReq, bOut, expOut(mAbDrive, abFollow, aIn, mAbStore));
    chk(abReq, bDrv, expDrv(mAbDrive));
    chk(baReq, aOut, expOut(mBaDrive, baFollow, bIn, mBaStore));
    chk(baReq, aDrv, expDrv(mBaDrive));
  endtask

  // drive after negedge, check 1 ns later (after posedge model update)
  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; aIn = '0; bIn = '0;
    abFollow = 0; abStrobe = 1; abDriveEn = 1;
    baFollow = 0; baStrobe = 1; baDriveEnN = 0;
    repeat (3) cyc();
    #1;
    // R7: reset state, drivers off
    chk("R7", bDrv, '0); chk("R7", aDrv, '0);
    chk("R7", bOut, '0); chk("R7", aOut, '0);
    rst = 1'b0;
    aIn = 18'h2AAAA; bIn = 18'h15555;
    cyc(); #1;
    // R7: strobes held high across reset must not load; stores still zero
    chk("R7", bOut, '0); chk("R7", aOut, '0);
    chk("R5", bDrv, {W{1'b1}}); chk("R6", aDrv, {W{1'b1}});

    // R1: transparent same cycle
    abFollow = 1; baFollow = 1; aIn = 18'h12345; bIn = 18'h0BEEF;
    #1;
    chk("R1", bOut, 18'h12345); chk("R6", aOut, 18'h0BEEF);
    cyc(); aIn = 18'h3C3C3; bIn = 18'h00F0F; #1;
    chk("R1", bOut, 18'h3C3C3); chk("R6", aOut, 18'h00F0F);
    cyc();
    // R2: follow falls, holds last sampled word
    abFollow = 0; baFollow = 0; aIn = 18'h11111; bIn = 18'h22222;
    #1;
    chk("R2", bOut, 18'h3C3C3); chk("R2", aOut, 18'h00F0F);
    // R3: input changes with steady strobe high: hold
    repeat (3) begin cyc(); aIn = aIn + 18'h1; bIn = bIn + 18'h3; end
    #1;
    chk("R3", bOut, 18'h3C3C3); chk("R3", aOut, 18'h00F0F);
    // R4: strobe low then high loads
    cyc(); abStrobe = 0; baStrobe = 0; aIn = 18'h0AAAA; bIn = 18'h35555;
    #1; chk("R3", bOut, 18'h3C3C3);
    cyc(); abStrobe = 1; baStrobe = 1; aIn = 18'h01234; bIn = 18'h04321;
    #1; chk("R4", bOut, 18'h3C3C3); // edge not yet sampled
    cyc(); aIn = 18'h3FFFF; bIn = 18'h3FFFF;
    #1; chk("R4", bOut, 18'h01234); chk("R4", aOut, 18'h04321);
    // R5/R6: disable both, polarity check
    abDriveEn = 0; baDriveEnN = 1;
    #1; chk("R5", bDrv, {W{1'b1}}); // registered: still on
    cyc(); #1;
    chk("R5", bDrv, '0); chk("R5", bOut, '0);
    chk("R6", aDrv, '0); chk("R6", aOut, '0);
    // R8: AB on, BA off independently
    abDriveEn = 1; abFollow = 1; aIn = 18'h2DEAD;
    cyc(); #1;
    chk("R8", bOut, 18'h2DEAD); chk("R8", aDrv, '0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      cyc();
      rst        = ($urandom_range(0, 199) == 0);
      aIn        = W'($urandom);
      bIn        = W'($urandom);
      abFollow   = ($urandom_range(0, 3) == 0);
      baFollow   = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) == 0) abStrobe = ~abStrobe;
      if ($urandom_range(0, 2) == 0) baStrobe = ~baStrobe;
      abDriveEn  = ($urandom_range(0, 7) != 0);
      baDriveEnN = ($urandom_range(0, 7) == 0);
      #1;
      chkAll(abFollow ? "R1" : "R4", baFollow ? "R6" : "R8");
    end
    rst = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule